// File: doc/BRIEF.md
# DRAM Rank Maintenance Sequencer

This block sits beside the transaction sequencer of a DRAM controller and handles the upkeep commands for one rank. For each new transaction it receives three times: when the previous transaction finished, when the previous precharge was issued, and when the new transaction arrived. It then decides whether the idle gap is long enough to put the rank into a low-power state. It also decides whether any refresh intervals have expired and must be caught up. The resulting commands come out one per cycle, each with a timestamp. When the sequence is complete, the block reports the earliest time at which the transaction sequencer may issue its next command.

A mode input chooses the policy: maintenance by refresh only, refresh plus active power-down, or self-refresh during idle gaps. A family input chooses how the wake-up latency is computed. Low-power families use the short exit latencies directly. Other families subtract the activate-to-column delay from the locked-loop exit latencies. The family input and all timing values are captured while reset is held and are frozen once reset is released.

Top module: `rfpd_manager`

## Requirements
- R1: After reset, busy_o, cmd_valid_o and done_o are low and blk_until_o is 0. Timing inputs and lp_family_i are captured only while rst is high; changing them afterwards has no effect.
- R2: A refresh deadline starts at t_refi. Refresh work begins when either the finish time or the arrival time is at or past the deadline. Each refresh handled moves the deadline on by t_refi.
- R3: A refresh (cmd_kind_o = 1) is stamped with the latest of: finish time, precharge time plus t_rp, current deadline, and current blocked-until. Blocked-until then becomes that stamp plus t_rfc.
- R4: When the arrival is late by several intervals, one refresh is produced for each deadline at or before the arrival time.
- R5: In power-down mode (mode_i = 1), let the base time be the later of max(finish, precharge + t_rp) and blocked-until. Let the limit be the earlier of the arrival time and the deadline. Entry (kind 2) at the base time happens only when the limit exceeds base + t_cke.
- R6: The power-down exit (kind 3) is at base + min(limit − base, t_refi). Blocked-until becomes exit + t_xp for low-power families, or exit + t_xpdll − t_rcd otherwise.
- R7: In self-refresh mode (mode_i = 2), the first check of each transaction uses the arrival time as its limit. Entry (kind 4) at the base time happens only when the limit exceeds base + t_ckesr. Exit (kind 5) is at the limit. Blocked-until becomes exit + t_xs for low-power families, or exit + t_xsdll − t_rcd otherwise.
- R8: Once self refresh has been entered for a transaction, no refresh command is emitted for it, but the deadline still advances for each interval that falls due.
- R9: After each refresh, outside self refresh, the power-down or self-refresh check is repeated. It uses the new deadline in the limit, so idle time between refreshes is also spent in the low-power state.
- R10: With mode_i = 0, no power-down or self-refresh command is ever produced.
- R11: done_o pulses for one cycle after the last command of a transaction, and blk_until_o then holds the final blocked-until time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; timing inputs sampled while high |
| mode_i | input | 2 | 0 refresh only, 1 power-down, 2 self-refresh |
| lp_family_i | input | 1 | 1 selects low-power-family exit latencies |
| t_refi_i | input | 16 | Refresh interval |
| t_rfc_i | input | 16 | Refresh cycle time |
| t_rp_i | input | 16 | Precharge period |
| t_cke_i | input | 16 | Minimum power-down residency |
| t_ckesr_i | input | 16 | Minimum self-refresh residency |
| t_xp_i | input | 16 | Power-down exit latency, low-power family |
| t_xpdll_i | input | 16 | Power-down exit latency, other families |
| t_xs_i | input | 16 | Self-refresh exit latency, low-power family |
| t_xsdll_i | input | 16 | Self-refresh exit latency, other families |
| t_rcd_i | input | 16 | Activate-to-column delay |
| req_valid_i | input | 1 | New transaction arrival, accepted when busy_o is low |
| fin_time_i | input | 32 | Finish time of the previous transaction |
| pre_time_i | input | 32 | Time of the previous precharge |
| arr_time_i | input | 32 | Arrival time of the new transaction |
| busy_o | output | 1 | Sequence in progress |
| cmd_valid_o | output | 1 | A maintenance command is presented this cycle |
| cmd_kind_o | output | 3 | 1 refresh, 2 PD entry, 3 PD exit, 4 SR entry, 5 SR exit |
| cmd_time_o | output | 32 | Timestamp of the presented command |
| done_o | output | 1 | Sequence for this arrival complete |
| blk_until_o | output | 32 | Earliest time the next command may issue |

## Verification
The key interplay is between a refresh deadline and a power-down exit that land on the same timestamp. In that case the exit latency pushes the refresh later, and the refresh in turn pushes the next power-down entry later. This is provoked with a long idle gap in power-down mode that spans two deadlines. The full command stream is then compared entry by entry against hand-derived timestamps. The same clash is also exercised under self refresh, where the refresh must vanish while the deadline still advances. That advance is judged through the absence of a refresh on the following arrival.

// File: rtl/rfpd_pkg.sv
package rfpd_pkg;

    localparam int TW = 32;
    localparam int PW = 16;

    typedef logic [TW-1:0] tstamp_t;
    typedef logic [PW-1:0] tparm_t;

    typedef enum logic [1:0] {
        MD_NONE = 2'd0,
        MD_PD   = 2'd1,
        MD_SR   = 2'd2
    } mode_e;

    typedef enum logic [2:0] {
        CK_NONE = 3'd0,
        CK_REF  = 3'd1,
        CK_PDE  = 3'd2,
        CK_PDX  = 3'd3,
        CK_SRE  = 3'd4,
        CK_SRX  = 3'd5
    } cmd_e;

    typedef struct packed {
        tparm_t refi;
        tparm_t rfc;
        tparm_t rp;
        tparm_t cke;
        tparm_t ckesr;
        tparm_t xp;
        tparm_t xpdll;
        tparm_t xs;
        tparm_t xsdll;
        tparm_t rcd;
    } tcfg_t;

    function automatic tstamp_t tmax(input tstamp_t a, input tstamp_t b);
        return (a > b) ? a : b;
    endfunction

    function automatic tstamp_t tmin(input tstamp_t a, input tstamp_t b);
        return (a < b) ? a : b;
    endfunction

    function automatic tstamp_t widen(input tparm_t p);
        return tstamp_t'(p);
    endfunction

endpackage

// File: rtl/rfpd_cfg_hold.sv
module rfpd_cfg_hold
    import rfpd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  tcfg_t cfg_in,
    input  logic  lp_in,
    output tcfg_t cfg_q,
    output logic  lp_q
);
    // Configuration follows its inputs only while reset is held.
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= cfg_in;
            lp_q  <= lp_in;
        end
    end
endmodule

// File: rtl/rfpd_idle_eval.sv
module rfpd_idle_eval
    import rfpd_pkg::*;
(
    input  mode_e   mode,
    input  logic    lp,
    input  tcfg_t   cfg,
    input  tstamp_t end_t,
    input  tstamp_t blk_t,
    input  tstamp_t limit_t,
    output logic    enter,
    output cmd_e    ent_kind,
    output cmd_e    ext_kind,
    output tstamp_t ent_time,
    output tstamp_t ext_time,
    output tstamp_t new_blk
);
    tstamp_t base_t, gap_t, resid_t, lat_t;
    logic    is_sr;

    always_comb begin
        is_sr    = (mode == MD_SR);
        base_t   = tmax(end_t, blk_t);
        gap_t    = (limit_t > base_t) ? (limit_t - base_t) : '0;
        resid_t  = is_sr ? widen(cfg.ckesr) : widen(cfg.cke);
        enter    = (mode != MD_NONE) && (limit_t > base_t + resid_t);
        ent_kind = is_sr ? CK_SRE : CK_PDE;
        ext_kind = is_sr ? CK_SRX : CK_PDX;
        ent_time = base_t;
        ext_time = is_sr ? (base_t + gap_t)
                         : (base_t + tmin(gap_t, widen(cfg.refi)));
        if (is_sr)
            lat_t = lp ? widen(cfg.xs) : widen(cfg.xsdll - cfg.rcd);
        else
            lat_t = lp ? widen(cfg.xp) : widen(cfg.xpdll - cfg.rcd);
        new_blk  = ext_time + lat_t;
    end
endmodule

// File: rtl/rfpd_ref_eval.sv
module rfpd_ref_eval
    import rfpd_pkg::*;
(
    input  tcfg_t   cfg,
    input  tstamp_t fin_t,
    input  tstamp_t pre_t,
    input  tstamp_t due_t,
    input  tstamp_t blk_t,
    output tstamp_t ref_time,
    output tstamp_t ref_blk,
    output tstamp_t due_next
);
    always_comb begin
        ref_time = tmax(tmax(fin_t, pre_t + widen(cfg.rp)), tmax(due_t, blk_t));
        ref_blk  = ref_time + widen(cfg.rfc);
        due_next = due_t + widen(cfg.refi);
    end
endmodule

// File: rtl/rfpd_manager.sv
module rfpd_manager
    import rfpd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  mode_i,
    input  logic        lp_family_i,
    input  logic [15:0] t_refi_i,
    input  logic [15:0] t_rfc_i,
    input  logic [15:0] t_rp_i,
    input  logic [15:0] t_cke_i,
    input  logic [15:0] t_ckesr_i,
    input  logic [15:0] t_xp_i,
    input  logic [15:0] t_xpdll_i,
    input  logic [15:0] t_xs_i,
    input  logic [15:0] t_xsdll_i,
    input  logic [15:0] t_rcd_i,
    input  logic        req_valid_i,
    input  logic [31:0] fin_time_i,
    input  logic [31:0] pre_time_i,
    input  logic [31:0] arr_time_i,
    output logic        busy_o,
    output logic        cmd_valid_o,
    output logic [2:0]  cmd_kind_o,
    output logic [31:0] cmd_time_o,
    output logic        done_o,
    output logic [31:0] blk_until_o
);
    typedef enum logic [2:0] {
        S_IDLE, S_IDLE_CHK, S_LP_EXIT, S_REF_CHK, S_REF, S_FIN
    } st_e;

    tcfg_t   cfg_in, cfg;
    logic    lp;
    st_e     st_q;
    mode_e   mode_q;
    tstamp_t fin_q, pre_q, arr_q, endt_q, due_q, blk_q;
    tstamp_t xt_q, xblk_q;
    cmd_e    xk_q;
    logic    insr_q, loop_q;

    assign cfg_in = '{refi: t_refi_i, rfc: t_rfc_i, rp: t_rp_i, cke: t_cke_i,
                      ckesr: t_ckesr_i, xp: t_xp_i, xpdll: t_xpdll_i,
                      xs: t_xs_i, xsdll: t_xsdll_i, rcd: t_rcd_i};

    rfpd_cfg_hold u_cfg (
        .clk(clk), .rst(rst), .cfg_in(cfg_in), .lp_in(lp_family_i),
        .cfg_q(cfg), .lp_q(lp)
    );

    tstamp_t limit_t;
    logic    ie_enter;
    cmd_e    ie_ek, ie_xk;
    tstamp_t ie_et, ie_xt, ie_blk;

    // First check under self refresh looks to the arrival; all others stop at the deadline.
    assign limit_t = (!loop_q && mode_q == MD_SR) ? arr_q : tmin(arr_q, due_q);

    rfpd_idle_eval u_idle (
        .mode(mode_q), .lp(lp), .cfg(cfg), .end_t(endt_q), .blk_t(blk_q),
        .limit_t(limit_t), .enter(ie_enter), .ent_kind(ie_ek), .ext_kind(ie_xk),
        .ent_time(ie_et), .ext_time(ie_xt), .new_blk(ie_blk)
    );

    tstamp_t rf_time, rf_blk, rf_due;

    rfpd_ref_eval u_ref (
        .cfg(cfg), .fin_t(fin_q), .pre_t(pre_q), .due_t(due_q), .blk_t(blk_q),
        .ref_time(rf_time), .ref_blk(rf_blk), .due_next(rf_due)
    );

    // Where to go once a low-power check (with or without an exit) is over.
    st_e after_lp;
    assign after_lp = !loop_q ? S_REF_CHK : ((due_q <= arr_q) ? S_REF : S_FIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            mode_q <= MD_NONE;
            fin_q  <= '0;
            pre_q  <= '0;
            arr_q  <= '0;
            endt_q <= '0;
            due_q  <= widen(t_refi_i);
            blk_q  <= '0;
            xt_q   <= '0;
            xblk_q <= '0;
            xk_q   <= CK_NONE;
            insr_q <= 1'b0;
            loop_q <= 1'b0;
        end else begin
            unique case (st_q)
                S_IDLE: if (req_valid_i) begin
                    mode_q <= mode_e'(mode_i);
                    fin_q  <= fin_time_i;
                    pre_q  <= pre_time_i;
                    arr_q  <= arr_time_i;
                    endt_q <= tmax(fin_time_i, pre_time_i + widen(cfg.rp));
                    insr_q <= 1'b0;
                    loop_q <= 1'b0;
                    st_q   <= (mode_e'(mode_i) == MD_NONE) ? S_REF_CHK : S_IDLE_CHK;
                end
                S_IDLE_CHK: begin
                    if (ie_enter) begin
                        xt_q   <= ie_xt;
                        xk_q   <= ie_xk;
                        xblk_q <= ie_blk;
                        if (mode_q == MD_SR) insr_q <= 1'b1;
                        st_q   <= S_LP_EXIT;
                    end else begin
                        st_q   <= after_lp;
                    end
                end
                S_LP_EXIT: begin
                    blk_q <= xblk_q;
                    st_q  <= after_lp;
                end
                S_REF_CHK: begin
                    if (fin_q >= due_q || arr_q >= due_q) begin
                        loop_q <= 1'b1;
                        st_q   <= S_REF;
                    end else begin
                        st_q   <= S_FIN;
                    end
                end
                S_REF: begin
                    due_q <= rf_due;
                    if (!insr_q) begin
                        blk_q <= rf_blk;
                        st_q  <= (mode_q == MD_NONE)
                                 ? ((rf_due <= arr_q) ? S_REF : S_FIN) : S_IDLE_CHK;
                    end else begin
                        st_q  <= (rf_due <= arr_q) ? S_REF : S_FIN;
                    end
                end
                S_FIN:   st_q <= S_IDLE;
                default: st_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd_valid_o = 1'b0;
        cmd_kind_o  = CK_NONE;
        cmd_time_o  = '0;
        unique case (st_q)
            S_IDLE_CHK: if (ie_enter) begin
                cmd_valid_o = 1'b1;
                cmd_kind_o  = ie_ek;
                cmd_time_o  = ie_et;
            end
            S_LP_EXIT: begin
                cmd_valid_o = 1'b1;
                cmd_kind_o  = xk_q;
                cmd_time_o  = xt_q;
            end
            S_REF: if (!insr_q) begin
                cmd_valid_o = 1'b1;
                cmd_kind_o  = CK_REF;
                cmd_time_o  = rf_time;
            end
            default: ;
        endcase
    end

    assign busy_o      = (st_q != S_IDLE);
    assign done_o      = (st_q == S_FIN);
    assign blk_until_o = blk_q;

    // R3
    ref_after_deadline_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_o && cmd_kind_o == CK_REF) |-> (cmd_time_o >= due_q && cmd_time_o >= blk_q));
    // R2
    deadline_step_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_REF) |=> (due_q == $past(due_q) + widen(cfg.refi)));
    // R8
    no_ref_in_sr_chk: assert property (@(posedge clk) disable iff (rst)
        insr_q |-> !(cmd_valid_o && cmd_kind_o == CK_REF));
    // R6
    exit_follows_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_o && (cmd_kind_o == CK_PDE || cmd_kind_o == CK_SRE))
        |=> (cmd_valid_o && (cmd_kind_o == CK_PDX || cmd_kind_o == CK_SRX)));
    // R10
    no_lp_in_none_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && mode_q == MD_NONE) |-> !(cmd_valid_o && cmd_kind_o != CK_REF));
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o && !busy_o));
endmodule

// File: tb/sim_rfpd_manager.sv
module sim_rfpd_manager;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = 2'd0;
    logic        lpf = 1'b0;
    logic [15:0] refi = 16'd100, rfc = 16'd10, rp = 16'd3, cke = 16'd4, ckesr = 16'd6;
    logic [15:0] xp = 16'd2, xpdll = 16'd12, xs = 16'd20, xsdll = 16'd30, rcd = 16'd5;
    logic        req = 1'b0;
    logic [31:0] fin = '0, pre = '0, arr = '0;
    logic        busy, cv, done;
    logic [2:0]  ck;
    logic [31:0] ct, blk;

    always #2.5 clk = ~clk;

    rfpd_manager u0 (
        .clk(clk), .rst(rst), .mode_i(mode), .lp_family_i(lpf),
        .t_refi_i(refi), .t_rfc_i(rfc), .t_rp_i(rp), .t_cke_i(cke), .t_ckesr_i(ckesr),
        .t_xp_i(xp), .t_xpdll_i(xpdll), .t_xs_i(xs), .t_xsdll_i(xsdll), .t_rcd_i(rcd),
        .req_valid_i(req), .fin_time_i(fin), .pre_time_i(pre), .arr_time_i(arr),
        .busy_o(busy), .cmd_valid_o(cv), .cmd_kind_o(ck), .cmd_time_o(ct),
        .done_o(done), .blk_until_o(blk)
    );

    int nvec = 0, nbad = 0;
    logic [2:0]  gk [16];
    logic [31:0] gt [16];
    int          ncmd;
    logic [31:0] gblk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] m, input logic l);
        rst  = 1'b1; mode = m; lpf = l; rfc = 16'd10; xpdll = 16'd12;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_txn(input logic [31:0] f, input logic [31:0] p, input logic [31:0] a);
        int cyc;
        ncmd = 0;
        fin = f; pre = p; arr = a; req = 1'b1;
        cyc = 0;
        forever begin
            @(negedge clk);
            req = 1'b0;
            cyc++;
            if (cv && ncmd < 16) begin gk[ncmd] = ck; gt[ncmd] = ct; ncmd++; end
            if (done) begin gblk = blk; break; end
            if (cyc > 2000) begin
                chk(1'b0, "watchdog", 32'(cyc), 32'd0);
                gblk = '1;
                break;
            end
        end
        @(negedge clk);
    endtask

    task automatic exp_cmd(input int i, input logic [2:0] k, input logic [31:0] t, input string tag);
        if (i >= ncmd) begin
            chk(1'b0, {tag, " missing cmd"}, 32'(ncmd), 32'(i + 1));
        end else begin
            chk(gk[i] == k, {tag, " kind"}, 32'(gk[i]), 32'(k));
            chk(gt[i] == t, {tag, " time"}, gt[i], t);
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !cv && !done, "R1 reset outputs", {29'd0, busy, cv, done}, 32'd0);
        chk(blk == 0, "R1 reset blk", blk, 32'd0);
    endtask

    task automatic t_none_quiet;
        do_reset(2'd0, 1'b0);
        run_txn(10, 5, 20);
        chk(ncmd == 0, "R10 no cmds", 32'(ncmd), 32'd0);
        chk(gblk == 0, "R11 blk", gblk, 32'd0);
    endtask

    task automatic t_single_ref;
        do_reset(2'd0, 1'b0);
        rfc = 16'd50;   // ignored after reset release (R1)
        run_txn(50, 48, 120);
        chk(ncmd == 1, "R2 count", 32'(ncmd), 32'd1);
        exp_cmd(0, 3'd1, 100, "R3 ref");
        chk(gblk == 110, "R1 cfg held / R3 blk", gblk, 32'd110);
    endtask

    task automatic t_catchup;
        do_reset(2'd0, 1'b0);
        run_txn(50, 48, 120);
        run_txn(130, 0, 450);
        chk(ncmd == 3, "R4 count", 32'(ncmd), 32'd3);
        exp_cmd(0, 3'd1, 200, "R4 ref0");
        exp_cmd(1, 3'd1, 300, "R4 ref1");
        exp_cmd(2, 3'd1, 400, "R4 ref2");
        chk(gblk == 410, "R4 blk", gblk, 32'd410);
    endtask

    task automatic t_fin_trigger;
        do_reset(2'd0, 1'b0);
        run_txn(120, 0, 110);
        chk(ncmd == 1, "R2 finish trigger count", 32'(ncmd), 32'd1);
        exp_cmd(0, 3'd1, 120, "R2 finish trigger");
        do_reset(2'd0, 1'b0);
        run_txn(100, 99, 100);
        exp_cmd(0, 3'd1, 102, "R3 precharge term");
        chk(gblk == 112, "R3 precharge blk", gblk, 32'd112);
    endtask

    task automatic t_pd_basic;
        do_reset(2'd1, 1'b0);
        run_txn(10, 5, 60);
        chk(ncmd == 2, "R5 count", 32'(ncmd), 32'd2);
        exp_cmd(0, 3'd2, 10, "R5 entry");
        exp_cmd(1, 3'd3, 60, "R6 exit");
        chk(gblk == 67, "R6 dll blk", gblk, 32'd67);
        do_reset(2'd1, 1'b1);
        run_txn(10, 5, 60);
        chk(gblk == 62, "R6 lp blk", gblk, 32'd62);
        do_reset(2'd1, 1'b0);
        run_txn(10, 5, 14);
        chk(ncmd == 0, "R5 gap at tcke", 32'(ncmd), 32'd0);
        chk(gblk == 0, "R5 gap blk", gblk, 32'd0);
    endtask

    task automatic t_pd_with_ref;
        do_reset(2'd1, 1'b0);
        run_txn(10, 5, 250);
        chk(ncmd == 8, "R9 count", 32'(ncmd), 32'd8);
        exp_cmd(0, 3'd2, 10, "R5 e0");
        exp_cmd(1, 3'd3, 100, "R6 x0");
        exp_cmd(2, 3'd1, 107, "R3 ref after exit");
        exp_cmd(3, 3'd2, 117, "R9 e1");
        exp_cmd(4, 3'd3, 200, "R9 x1");
        exp_cmd(5, 3'd1, 207, "R4 ref1");
        exp_cmd(6, 3'd2, 217, "R9 e2");
        exp_cmd(7, 3'd3, 250, "R9 x2");
        chk(gblk == 257, "R11 blk", gblk, 32'd257);
    endtask

    task automatic t_sr;
        do_reset(2'd2, 1'b0);
        run_txn(10, 5, 60);
        exp_cmd(0, 3'd4, 10, "R7 entry");
        exp_cmd(1, 3'd5, 60, "R7 exit");
        chk(gblk == 85, "R7 dll blk", gblk, 32'd85);
        do_reset(2'd2, 1'b1);
        run_txn(10, 5, 60);
        chk(gblk == 80, "R7 lp blk", gblk, 32'd80);
        do_reset(2'd2, 1'b0);
        run_txn(10, 5, 16);
        chk(ncmd == 0, "R7 gap at tckesr", 32'(ncmd), 32'd0);
    endtask

    task automatic t_sr_suppress;
        do_reset(2'd2, 1'b0);
        run_txn(10, 5, 350);
        chk(ncmd == 2, "R8 no ref count", 32'(ncmd), 32'd2);
        exp_cmd(0, 3'd4, 10, "R8 entry");
        exp_cmd(1, 3'd5, 350, "R8 exit");
        chk(gblk == 375, "R8 blk", gblk, 32'd375);
        run_txn(360, 0, 390);
        chk(ncmd == 2, "R8 deadline advanced", 32'(ncmd), 32'd2);
        exp_cmd(0, 3'd4, 375, "R8 next entry");
        exp_cmd(1, 3'd5, 390, "R8 next exit");
        chk(gblk == 415, "R8 next blk", gblk, 32'd415);
    endtask

    initial begin
        t_reset;
        t_none_quiet;
        t_single_ref;
        t_catchup;
        t_fin_trigger;
        t_pd_basic;
        t_pd_with_ref;
        t_sr;
        t_sr_suppress;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        #900000;
        nvec++; nbad++;
        $display("FAIL watchdog global timeout actual=1 expected=0");
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule